// File: doc/BRIEF.md
# Configuration Access Router

This block takes configuration read and write requests, each carrying a 24-bit address, and steers them to one function on a tree of buses. The root bus always carries bus number 0. Every other bus sits behind a bridge. The number of that bus is whatever software has last written into the bridge's secondary-bus byte. The router keeps its own copy of each bridge's secondary number by watching writes that reach the bridge function. This lets the bus numbering change at run time without a separate programming path.

Downstream, all functions share one target port. The router drives the resolved bus index, the device/function, the register offset, the length and the write data. The function addressed by that index and device/function answers in the same cycle with a presence flag and its read data. A read always completes with a single response one cycle after the request. A read that finds no bus or no function returns all ones, sized to the access length. A write that finds no bus or no function is dropped.

Top module: `cfg_access_router`

## Requirements
- R1: For a request, the register offset is address bits 7:0 and the device/function number is address bits 15:8, with device/function = slot*8 + function. Both are presented unchanged on `tgt_offset` and `tgt_devfn`, together with `tgt_len`.
- R2: The root bus has bus number 0 and bus index 0. A request whose address bits 23:16 equal 0 always goes to index 0.
- R3: Bridge k (parameters `BRIDGE_PARENT`, `BRIDGE_DEVFN`) owns bus index k+1. The number of that bus is the byte at offset 0x19 of the bridge's function. This number resets to 0 and is updated by every delivered write that covers byte 0x19.
- R4: A request whose bus number equals a bridge's secondary number goes to that bridge's bus index.
- R5: When several buses carry the same number, the one with the lowest index is selected.
- R6: The length code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 = 4 bytes. A read with no matching bus, or with `tgt_present` low, returns 0xFF, 0xFFFF or 0xFFFFFFFF for 1, 2 or 4 bytes.
- R7: A write to an unmatched bus or to an absent function never raises `tgt_wr` and leaves every secondary bus number unchanged. Writes that do not cover byte 0x19 of a bridge function, or that land on a function that is not a bridge, also leave the numbers unchanged.
- R8: Every read produces exactly one cycle of `rsp_valid`, in the cycle after the request. On a hit, `rsp_rdata` is `tgt_rdata` with the bytes above the access length cleared.
- R9: A write produces no `rsp_valid`.
- R10: A multi-byte write starting below 0x19 takes the secondary number from byte lane (0x19 - offset) of the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus number, device/function and register offset |
| req_len | input | 2 | Access length code |
| req_wdata | input | 32 | Write data, lowest byte goes to the lowest offset |
| rsp_valid | output | 1 | Read completion pulse |
| rsp_rdata | output | 32 | Read completion data |
| tgt_bus | output | BIDX_W | Resolved bus index (0 = root, k+1 = behind bridge k) |
| tgt_devfn | output | 8 | Device/function on the resolved bus |
| tgt_offset | output | 8 | Register offset |
| tgt_len | output | 2 | Access length code |
| tgt_wdata | output | 32 | Write data to the target |
| tgt_rd | output | 1 | Read strobe to the resolved bus |
| tgt_wr | output | 1 | Write strobe to a present function |
| tgt_present | input | 1 | Function at tgt_bus/tgt_devfn exists |
| tgt_rdata | input | 32 | Read data from that function |

## Verification
The assertions assume that `tgt_present` and `tgt_rdata` are pure combinational functions of the shared target port. The bench's target model is built this way, so presence always follows the currently presented bus index and device/function. The assertions also assume the requester holds each request for exactly one cycle. The bench drives every request away from the clock edge and clears it one cycle later. The bench checks bus renumbering only through the routing of later reads, because the secondary numbers are not visible on any port.

// File: rtl/cfg_access_router.sv
module cfg_access_router #(
  parameter int NUM_BRIDGE = 2,
  parameter logic [NUM_BRIDGE*8-1:0] BRIDGE_PARENT = {8'd1, 8'd0},
  parameter logic [NUM_BRIDGE*8-1:0] BRIDGE_DEVFN  = {8'h18, 8'h08},
  parameter logic [7:0] SEC_BUS_OFFSET = 8'h19,
  localparam int NUM_BUS = NUM_BRIDGE + 1,
  localparam int BIDX_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [23:0]       req_addr,
  input  logic [1:0]        req_len,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [BIDX_W-1:0] tgt_bus,
  output logic [7:0]        tgt_devfn,
  output logic [7:0]        tgt_offset,
  output logic [1:0]        tgt_len,
  output logic [31:0]       tgt_wdata,
  output logic              tgt_rd,
  output logic              tgt_wr,
  input  logic              tgt_present,
  input  logic [31:0]       tgt_rdata
);

  logic [7:0] req_busno;
  logic [7:0] sec_q  [NUM_BRIDGE];
  logic [7:0] bus_no [NUM_BUS];
  logic              bus_hit;
  logic [BIDX_W-1:0] bus_idx;

  assign req_busno  = req_addr[23:16];
  assign tgt_devfn  = req_addr[15:8];
  assign tgt_offset = req_addr[7:0];
  assign tgt_len    = req_len;
  assign tgt_wdata  = req_wdata;

  assign bus_no[0] = 8'h00;

  always_comb begin
    bus_hit = 1'b0;
    bus_idx = '0;
    for (int i = NUM_BUS - 1; i >= 0; i--) begin
      if (bus_no[i] == req_busno) begin
        bus_hit = 1'b1;
        bus_idx = BIDX_W'(i);
      end
    end
  end

  assign tgt_bus = bus_idx;
  assign tgt_rd  = req_valid && !req_write && bus_hit;
  assign tgt_wr  = req_valid &&  req_write && bus_hit && tgt_present;

  logic [31:0] len_mask;
  logic [2:0]  len_bytes;
  assign len_mask  = (req_len == 2'd0) ? 32'h0000_00FF :
                     (req_len == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign len_bytes = (req_len == 2'd0) ? 3'd1 : (req_len == 2'd1) ? 3'd2 : 3'd4;

  logic [7:0] lane_dist;
  logic       sec_covered;
  logic [7:0] sec_byte;
  assign lane_dist   = SEC_BUS_OFFSET - tgt_offset;
  assign sec_covered = (tgt_offset <= SEC_BUS_OFFSET) && (lane_dist < {5'd0, len_bytes});
  assign sec_byte    = 8'(req_wdata >> {lane_dist[1:0], 3'b000});

  for (genvar k = 0; k < NUM_BRIDGE; k++) begin : g_bridge
    localparam logic [7:0] PDEVFN = BRIDGE_DEVFN[k*8 +: 8];
    localparam logic [7:0] PIDX   = BRIDGE_PARENT[k*8 +: 8];
    logic snoop;
    assign snoop = tgt_wr && sec_covered && (tgt_bus == BIDX_W'(PIDX)) && (tgt_devfn == PDEVFN);

    always_ff @(posedge clk) begin
      if (!rst_n)     sec_q[k] <= 8'h00;
      else if (snoop) sec_q[k] <= sec_byte;
    end

    assign bus_no[k+1] = sec_q[k];

    p_sec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_wr |=> $stable(sec_q[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write)
        rsp_rdata <= (tgt_rd && tgt_present) ? (tgt_rdata & len_mask) : len_mask;
    end
  end

  p_rd_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  p_no_wr_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  p_miss_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!tgt_rd)) |->
      (rsp_rdata == (($past(req_len) == 2'd0) ? 32'hFF :
                     ($past(req_len) == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF)));
  p_hit_trim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(tgt_rd && tgt_present && req_len == 2'd0)) |-> (rsp_rdata[31:8] == 24'h0));
  p_wr_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr |-> (tgt_present && req_write));
  p_root_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_rd && req_addr[23:16] == 8'h00) |-> (tgt_bus == '0));

endmodule

// File: tb/tb_cfg_access_router.sv
`timescale 1ns/1ps
module tb_cfg_access_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [23:0] req_addr;
  logic [1:0]  req_len;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  tgt_bus;
  logic [7:0]  tgt_devfn, tgt_offset;
  logic [1:0]  tgt_len;
  logic [31:0] tgt_wdata;
  logic        tgt_rd, tgt_wr, tgt_present;
  logic [31:0] tgt_rdata;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cfg_access_router dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tgt_bus(tgt_bus),
    .tgt_devfn(tgt_devfn), .tgt_offset(tgt_offset), .tgt_len(tgt_len),
    .tgt_wdata(tgt_wdata), .tgt_rd(tgt_rd), .tgt_wr(tgt_wr),
    .tgt_present(tgt_present), .tgt_rdata(tgt_rdata));

  function automatic logic is_present(input logic [1:0] b, input logic [7:0] d);
    return (b == 2'd0 && (d == 8'h00 || d == 8'h08 || d == 8'h10)) ||
           (b == 2'd1 && (d == 8'h18 || d == 8'h21)) ||
           (b == 2'd2 && d == 8'h05);
  endfunction

  function automatic logic [31:0] model_data(input logic [1:0] b, input logic [7:0] d, input logic [7:0] o);
    return {6'd0, b, d, o, 8'h5A};
  endfunction

  function automatic logic [31:0] ones(input logic [1:0] len);
    return (len == 2'd0) ? 32'hFF : (len == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign tgt_present = is_present(tgt_bus, tgt_devfn);
  assign tgt_rdata   = model_data(tgt_bus, tgt_devfn, tgt_offset);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_read(input logic [7:0] bus, input logic [7:0] devfn, input logic [7:0] off,
                         input logic [1:0] len, input int exp_idx, input string tag);
    logic [31:0] exp;
    exp = (exp_idx < 0) ? ones(len) : (model_data(2'(exp_idx), devfn, off) & ones(len));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {bus, devfn, off}; req_len = len; req_wdata = '0;
    #1;
    if (exp_idx >= 0) begin
      check(tgt_rd && tgt_bus == 2'(exp_idx), {tag, " R4 route"}, {30'd0, tgt_bus}, exp_idx);
      check(tgt_devfn == devfn && tgt_offset == off && tgt_len == len, {tag, " R1 fields"},
            {16'd0, tgt_devfn, tgt_offset}, {16'd0, devfn, off});
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid, {tag, " R8 valid"}, {31'd0, rsp_valid}, 1);
    check(rsp_rdata == exp, {tag, " data"}, rsp_rdata, exp);
    @(negedge clk);
    check(!rsp_valid, {tag, " R8 single pulse"}, {31'd0, rsp_valid}, 0);
  endtask

  task automatic do_write(input logic [7:0] bus, input logic [7:0] devfn, input logic [7:0] off,
                          input logic [1:0] len, input logic [31:0] data, input logic exp_wr, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {bus, devfn, off}; req_len = len; req_wdata = data;
    #1;
    check(tgt_wr == exp_wr, {tag, " R7 strobe"}, {31'd0, tgt_wr}, {31'd0, exp_wr});
    @(negedge clk);
    req_valid = 1'b0;
    check(!rsp_valid, {tag, " R9 no response"}, {31'd0, rsp_valid}, 0);
  endtask

  task automatic t_reset;
    check(!rsp_valid && !tgt_rd && !tgt_wr, "reset R8", {29'd0, rsp_valid, tgt_rd, tgt_wr}, 0);
  endtask

  task automatic t_root_reads;
    do_read(8'h00, 8'h10, 8'h40, 2'd2, 0, "root len4 R2");
    do_read(8'h00, 8'h10, 8'h40, 2'd1, 0, "root len2 R8");
    do_read(8'h00, 8'h10, 8'h40, 2'd0, 0, "root len1 R8");
    do_read(8'h00, 8'h00, 8'h3C, 2'd3, 0, "root len3 R6");
  endtask

  task automatic t_misses;
    do_read(8'h00, 8'h30, 8'h00, 2'd0, -1, "empty len1 R6");
    do_read(8'h00, 8'h30, 8'h00, 2'd1, -1, "empty len2 R6");
    do_read(8'h00, 8'h30, 8'h00, 2'd2, -1, "empty len4 R6");
    do_read(8'h07, 8'h10, 8'h00, 2'd3, -1, "nobus len3 R6");
  endtask

  task automatic t_reset_dup;
    do_read(8'h00, 8'h21, 8'h00, 2'd2, -1, "dup at reset R5");
  endtask

  task automatic t_program;
    do_write(8'h00, 8'h08, 8'h19, 2'd0, 32'h0000_0005, 1'b1, "bridge0 byte R3");
    do_read(8'h05, 8'h21, 8'h08, 2'd2, 1, "bus5 R3");
    do_write(8'h05, 8'h18, 8'h18, 2'd1, 32'h0000_0900, 1'b1, "bridge1 lane1 R10");
    do_read(8'h09, 8'h05, 8'h00, 2'd2, 2, "bus9 R10");
    do_write(8'h05, 8'h18, 8'h16, 2'd2, 32'h0C00_0000, 1'b1, "bridge1 lane3 R10");
    do_read(8'h0C, 8'h05, 8'h04, 2'd2, 2, "bus12 R10");
    do_read(8'h09, 8'h05, 8'h00, 2'd2, -1, "old bus9 gone R3");
  endtask

  task automatic t_discards;
    do_write(8'h33, 8'h08, 8'h19, 2'd0, 32'h0000_0021, 1'b0, "nobus wr R7");
    do_write(8'h00, 8'h30, 8'h19, 2'd0, 32'h0000_0022, 1'b0, "empty wr R7");
    do_write(8'h05, 8'h18, 8'h1A, 2'd2, 32'h0000_0023, 1'b1, "offset miss R7");
    do_write(8'h00, 8'h10, 8'h19, 2'd0, 32'h0000_0044, 1'b1, "non-bridge R7");
    do_read(8'h0C, 8'h05, 8'h00, 2'd0, 2, "bus12 kept R7");
    do_read(8'h05, 8'h21, 8'h00, 2'd0, 1, "bus5 kept R7");
    do_read(8'h44, 8'h05, 8'h00, 2'd0, -1, "no bus44 R7");
    do_read(8'h23, 8'h05, 8'h00, 2'd0, -1, "no bus23 R7");
  endtask

  task automatic t_duplicate;
    do_write(8'h00, 8'h08, 8'h18, 2'd1, 32'h0000_0C00, 1'b1, "bridge0 to 12 R5");
    do_read(8'h0C, 8'h21, 8'h00, 2'd2, 1, "dup low wins R5");
    do_read(8'h0C, 8'h05, 8'h00, 2'd2, -1, "dup hides higher R5");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_root_reads();
    t_misses();
    t_reset_dup();
    t_program();
    t_discards();
    t_duplicate();
    report();
  end
endmodule